// File: doc/BRIEF.md
# Passive-Matrix LCD Scan Timing Generator

This block drives the timing side of a passive-matrix LCD panel. From a fast system clock it derives a pixel shift clock, a line pulse at the end of every row, a frame marker on the first row of every frame, and an AC-bias square wave that flips after a programmable number of rows. It also presents the panel data lanes, pulling one data word per shift-clock period from an upstream valid/ready pixel stream.

All timing comes from plain configuration inputs: a clock divisor N (shift clock = system clock / (2N+2)), the number of data transfers per row minus one, the number of rows minus one, and the bias divisor. The data lanes carry 4 bits for a single non-split panel, 8 bits for an 8-bit non-split panel, or two 4-bit nibbles for a split (dual-scan) panel, where the row count covers one half and both halves are scanned together. Enable, display-on and invert inputs control the outputs, and the current row number is visible on a status output.

Stream rules: `pix_ready` is high for exactly one system-clock cycle at the start of every transfer period. The word on `pix_data` is taken in that cycle if `pix_valid` is high. The source cannot stall the panel, so a transfer that finds `pix_valid` low is shown as all-zero data and the word is not taken. Outside the ready cycle the stream inputs are ignored.

Top module: `lcd_scan_timer`

## Requirements
- R1: While `cfg_enable` is low, every panel output (`lcd_sclk`, `lcd_line`, `lcd_frame`, `lcd_bias`, `lcd_data`), `pix_ready` and `cur_line` are 0, from the same cycle on. All counters are cleared, so the first cycle after enable rises is cycle 0 of transfer 0 of row 0.
- R2: Every transfer period lasts 2N+2 system cycles. `lcd_sclk` is low for the first N+1 cycles of the period and high for the last N+1. During a line-pulse period `lcd_sclk` stays low.
- R3: Each row consists of H+1 transfer periods followed by exactly one line-pulse period, where H is `cfg_xfer_last`. `lcd_line` is high for that whole period.
- R4: `cur_line` starts at 0 and advances by one at the end of each line-pulse period. After the value `cfg_line_last` it wraps to 0.
- R5: `lcd_frame` is high for the whole of row 0 and low on every other row.
- R6: `lcd_bias` starts low after enable and toggles each time another `cfg_bias_last`+1 rows have completed. Its count runs on across frame boundaries.
- R7: `pix_ready` is high only in the first cycle of each transfer period. The word taken there appears on `lcd_data` from the next cycle to the end of the period. If `pix_valid` is low in that cycle, the transfer is all zero. Stream inputs in any other cycle have no effect.
- R8: Lane packing: when `cfg_split` or `cfg_wide8` is 1, all 8 bits of `lcd_data` are driven. In split mode [3:0] is the upper-half nibble and [7:4] is the lower-half nibble. When both are 0, only [3:0] is driven and [7:4] is 0.
- R9: With `cfg_invert` = 1, every driven data bit is complemented at the output. Bits that are not driven stay 0.
- R10: With `cfg_disp_on` = 0, `lcd_data` is 0 while the scan timing continues unchanged.
- R11: `lcd_data` is 0 during every line-pulse period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Scan enable; low holds everything cleared |
| cfg_disp_on | input | 1 | Low blanks the data lanes |
| cfg_invert | input | 1 | Complement driven data bits |
| cfg_split | input | 1 | Dual-scan panel, two nibbles per transfer |
| cfg_wide8 | input | 1 | 8-bit non-split data lanes |
| cfg_clk_div | input | 5 | N; shift clock = clk/(2N+2) |
| cfg_xfer_last | input | 9 | Transfers per row minus one |
| cfg_line_last | input | 10 | Rows per frame (per half when split) minus one |
| cfg_bias_last | input | 8 | Rows per bias half-period minus one |
| pix_valid | input | 1 | Upstream word valid |
| pix_ready | output | 1 | Word taken this cycle (one cycle per transfer) |
| pix_data | input | 8 | Upstream pixel word |
| lcd_sclk | output | 1 | Pixel shift clock |
| lcd_line | output | 1 | Line pulse |
| lcd_frame | output | 1 | Frame marker (row 0) |
| lcd_bias | output | 1 | AC-bias signal |
| lcd_data | output | 8 | Panel data lanes |
| cur_line | output | 10 | Current row number |

## Verification
The bound checker watches rules that hold in every cycle. While disabled, everything is quiet. The shift clock never pulses during a line pulse, and data is blank during line pulses and while the display is off. The upper lanes stay 0 in 4-bit mode. The row counter and the bias output change only as a line pulse ends. The frame marker rises only after a line pulse. Data stays stable between ready cycles. The exact period lengths, the number of transfers per row, the wrap points at extreme field values, the value and order of the data words, underrun zeroing and inversion can only be shown by the bench. It compares every output in every cycle against positions computed from the cycle index.

// File: rtl/lcd_tim_pkg.sv
package lcd_tim_pkg;
  localparam int NIB_W = 4;
  localparam int PIX_W = 2 * NIB_W;

  typedef enum logic {
    SLOT_XFER = 1'b0,
    SLOT_LINE = 1'b1
  } slot_e;

  // Lanes driven for the selected data arrangement.
  function automatic logic [PIX_W-1:0] lane_mask(input logic split, input logic wide8);
    return (split || wide8) ? {PIX_W{1'b1}} : {{NIB_W{1'b0}}, {NIB_W{1'b1}}};
  endfunction
endpackage

// File: rtl/lcd_clk_div.sv
// Prescaler: each half of the shift clock lasts div+1 system cycles.
module lcd_clk_div #(
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             phase_hi,
  output logic             at_start,
  output logic             at_end
);
  logic [DIV_W-1:0] cnt_q;
  logic             half_q;
  logic             wrap;

  assign wrap     = (cnt_q >= div);
  assign phase_hi = half_q;
  assign at_start = (cnt_q == '0) && !half_q;
  assign at_end   = wrap && half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else if (!run) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      half_q <= ~half_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/lcd_scan_ctr.sv
// Transfer / line-pulse slot sequencing, row counter and bias divider.
module lcd_scan_ctr
  import lcd_tim_pkg::*;
#(
  parameter int XFER_W = 9,
  parameter int LINE_W = 10,
  parameter int BIAS_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              step,
  input  logic [XFER_W-1:0] xfer_last,
  input  logic [LINE_W-1:0] line_last,
  input  logic [BIAS_W-1:0] bias_last,
  output logic              in_line,
  output logic [LINE_W-1:0] line_num,
  output logic              bias
);
  slot_e             slot_q;
  logic [XFER_W-1:0] xfer_q;
  logic [LINE_W-1:0] line_q;
  logic [BIAS_W-1:0] bias_cnt_q;
  logic              bias_q;
  logic              row_done;

  assign row_done = step && (slot_q == SLOT_LINE);
  assign in_line  = (slot_q == SLOT_LINE);
  assign line_num = line_q;
  assign bias     = bias_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= SLOT_XFER;
      xfer_q <= '0;
    end else if (!run) begin
      slot_q <= SLOT_XFER;
      xfer_q <= '0;
    end else if (step) begin
      if (slot_q == SLOT_LINE) begin
        slot_q <= SLOT_XFER;
        xfer_q <= '0;
      end else if (xfer_q >= xfer_last) begin
        slot_q <= SLOT_LINE;
      end else begin
        xfer_q <= xfer_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
    end else if (!run) begin
      line_q <= '0;
    end else if (row_done) begin
      line_q <= (line_q >= line_last) ? '0 : line_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bias_cnt_q <= '0;
      bias_q     <= 1'b0;
    end else if (!run) begin
      bias_cnt_q <= '0;
      bias_q     <= 1'b0;
    end else if (row_done) begin
      if (bias_cnt_q >= bias_last) begin
        bias_cnt_q <= '0;
        bias_q     <= ~bias_q;
      end else begin
        bias_cnt_q <= bias_cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lcd_pix_path.sv
// Captures one stream word per transfer and shapes it for the panel lanes.
module lcd_pix_path
  import lcd_tim_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             take,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_data,
  input  logic             split,
  input  logic             wide8,
  input  logic             disp_on,
  input  logic             invert,
  input  logic             blank,
  output logic [PIX_W-1:0] lanes
);
  logic [PIX_W-1:0] word_q;
  logic [PIX_W-1:0] mask;
  logic [PIX_W-1:0] shaped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (!run) begin
      word_q <= '0;
    end else if (take) begin
      word_q <= pix_valid ? pix_data : '0;
    end
  end

  assign mask   = lane_mask(split, wide8);
  assign shaped = (invert ? ~word_q : word_q) & mask;
  assign lanes  = (run && disp_on && !blank) ? shaped : '0;
endmodule

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer
  import lcd_tim_pkg::*;
#(
  parameter int DIV_W  = 5,
  parameter int XFER_W = 9,
  parameter int LINE_W = 10,
  parameter int BIAS_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic              cfg_disp_on,
  input  logic              cfg_invert,
  input  logic              cfg_split,
  input  logic              cfg_wide8,
  input  logic [DIV_W-1:0]  cfg_clk_div,
  input  logic [XFER_W-1:0] cfg_xfer_last,
  input  logic [LINE_W-1:0] cfg_line_last,
  input  logic [BIAS_W-1:0] cfg_bias_last,
  input  logic              pix_valid,
  output logic              pix_ready,
  input  logic [PIX_W-1:0]  pix_data,
  output logic              lcd_sclk,
  output logic              lcd_line,
  output logic              lcd_frame,
  output logic              lcd_bias,
  output logic [PIX_W-1:0]  lcd_data,
  output logic [LINE_W-1:0] cur_line
);
  logic              phase_hi;
  logic              at_start;
  logic              at_end;
  logic              in_line;
  logic              bias_raw;
  logic [LINE_W-1:0] line_num;
  logic              take;

  lcd_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (cfg_enable),
    .div      (cfg_clk_div),
    .phase_hi (phase_hi),
    .at_start (at_start),
    .at_end   (at_end)
  );

  lcd_scan_ctr #(.XFER_W(XFER_W), .LINE_W(LINE_W), .BIAS_W(BIAS_W)) u_scan (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (cfg_enable),
    .step      (at_end),
    .xfer_last (cfg_xfer_last),
    .line_last (cfg_line_last),
    .bias_last (cfg_bias_last),
    .in_line   (in_line),
    .line_num  (line_num),
    .bias      (bias_raw)
  );

  assign take = cfg_enable && at_start && !in_line;

  lcd_pix_path u_pix (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (cfg_enable),
    .take      (take),
    .pix_valid (pix_valid),
    .pix_data  (pix_data),
    .split     (cfg_split),
    .wide8     (cfg_wide8),
    .disp_on   (cfg_disp_on),
    .invert    (cfg_invert),
    .blank     (in_line),
    .lanes     (lcd_data)
  );

  assign pix_ready = take;
  assign lcd_sclk  = cfg_enable && phase_hi && !in_line;
  assign lcd_line  = cfg_enable && in_line;
  assign lcd_frame = cfg_enable && (line_num == '0);
  assign lcd_bias  = cfg_enable && bias_raw;
  assign cur_line  = cfg_enable ? line_num : '0;
endmodule

// File: rtl/lcd_scan_timer_chk.sv
module lcd_scan_timer_chk #(
  parameter int LINE_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_enable,
  input logic              cfg_disp_on,
  input logic              cfg_invert,
  input logic              cfg_split,
  input logic              cfg_wide8,
  input logic [LINE_W-1:0] cfg_line_last,
  input logic              pix_ready,
  input logic              lcd_sclk,
  input logic              lcd_line,
  input logic              lcd_frame,
  input logic              lcd_bias,
  input logic [7:0]        lcd_data,
  input logic [LINE_W-1:0] cur_line
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |-> (!lcd_sclk && !lcd_line && !lcd_frame && !lcd_bias &&
                     lcd_data == '0 && !pix_ready && cur_line == '0));

  p_no_sclk_in_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_line |-> !lcd_sclk);

  p_row_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && $past(cfg_enable) && $fell(lcd_line) && $stable(cfg_line_last)) |->
      cur_line == (($past(cur_line) >= cfg_line_last) ? '0 : LINE_W'($past(cur_line) + 1'b1)));

  p_row_only_at_line_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && $past(cfg_enable) && cur_line != $past(cur_line)) |-> $fell(lcd_line));

  p_frame_after_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(lcd_frame) && $past(cfg_enable)) |-> $past(lcd_line));

  p_bias_at_line_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && $past(cfg_enable) && lcd_bias != $past(lcd_bias)) |-> $fell(lcd_line));

  p_ready_in_xfer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |-> (!lcd_line && !lcd_sclk));

  p_data_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && $past(cfg_enable) && !$past(pix_ready) && !lcd_line && !$past(lcd_line) &&
     $stable(cfg_invert) && $stable(cfg_disp_on) && $stable(cfg_split) && $stable(cfg_wide8))
      |-> $stable(lcd_data));

  p_upper_lanes_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_split && !cfg_wide8) |-> lcd_data[7:4] == 4'h0);

  p_blank_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_disp_on |-> lcd_data == '0);

  p_blank_in_line_r11: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_line |-> lcd_data == '0);
endmodule

bind lcd_scan_timer lcd_scan_timer_chk #(.LINE_W(LINE_W)) u_chk (.*);

// File: tb/test_lcd_scan_timer.sv
`timescale 1ns/1ps
module test_lcd_scan_timer;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, en, don, inv, spl, w8, pv;
  logic [4:0] div;
  logic [8:0] xl;
  logic [9:0] ll;
  logic [7:0] bl, pd;
  logic       pix_ready, lcd_sclk, lcd_line, lcd_frame, lcd_bias;
  logic [7:0] lcd_data;
  logic [9:0] cur_line;
  bit         under;
  int         n_chk = 0;
  int         n_bad = 0;

  lcd_scan_timer i_lcd_scan_timer (
    .clk(clk), .rst_n(rst_n), .cfg_enable(en), .cfg_disp_on(don), .cfg_invert(inv),
    .cfg_split(spl), .cfg_wide8(w8), .cfg_clk_div(div), .cfg_xfer_last(xl),
    .cfg_line_last(ll), .cfg_bias_last(bl), .pix_valid(pv), .pix_ready(pix_ready),
    .pix_data(pd), .lcd_sclk(lcd_sclk), .lcd_line(lcd_line), .lcd_frame(lcd_frame),
    .lcd_bias(lcd_bias), .lcd_data(lcd_data), .cur_line(cur_line)
  );

  function automatic logic [7:0] word_of(int j);
    return 8'((j * 29 + 7) & 255);
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_quiet(string tag);
    chk(tag, "sclk", int'(lcd_sclk), 0);
    chk(tag, "line", int'(lcd_line), 0);
    chk(tag, "frame", int'(lcd_frame), 0);
    chk(tag, "bias", int'(lcd_bias), 0);
    chk(tag, "data", int'(lcd_data), 0);
    chk(tag, "ready", int'(pix_ready), 0);
    chk(tag, "cur_line", int'(cur_line), 0);
  endtask

  // Expected outputs for cycle c after enable, derived from the requirements.
  task automatic sample(int c);
    int p, k, r, per_row, s, gl, j, m, w, e;
    bit lp;
    p       = 2 * int'(div) + 2;
    k       = c / p;
    r       = c % p;
    per_row = int'(xl) + 2;
    s       = k % per_row;
    gl      = k / per_row;
    lp      = (s == int'(xl) + 1);
    j       = gl * (int'(xl) + 1) + s;
    chk("R2", "sclk", int'(lcd_sclk), (!lp && r >= int'(div) + 1) ? 1 : 0);
    chk("R3", "line", int'(lcd_line), lp ? 1 : 0);
    chk("R4", "cur_line", int'(cur_line), gl % (int'(ll) + 1));
    chk("R5", "frame", int'(lcd_frame), (gl % (int'(ll) + 1) == 0) ? 1 : 0);
    chk("R6", "bias", int'(lcd_bias), (gl / (int'(bl) + 1)) % 2);
    chk("R7", "ready", int'(pix_ready), (!lp && r == 0) ? 1 : 0);
    if (lp) begin
      chk("R11", "data", int'(lcd_data), 0);
    end else if (r >= 1) begin
      m = (spl || w8) ? 255 : 15;
      w = (under && (j % 3 == 2)) ? 0 : int'(word_of(j));
      e = !don ? 0 : (inv ? ((~w) & m) : (w & m));
      chk(!don ? "R10" : (inv ? "R9" : "R8"), "data", int'(lcd_data), e);
    end
    if (!lp && r == 0) begin
      pv = !(under && (j % 3 == 2));
      pd = word_of(j);
    end else begin
      pv = c[0];
      pd = 8'h5A ^ 8'(c);
    end
  endtask

  task automatic run_case(int n, int h, int l, int d, bit s, bit w, bit iv, bit dn, bit un);
    int rows, total;
    @(negedge clk);
    en = 1'b0;
    div = 5'(n); xl = 9'(h); ll = 10'(l); bl = 8'(d);
    spl = s; w8 = w; inv = iv; don = dn; under = un;
    @(negedge clk);
    @(negedge clk);
    check_quiet("R1");
    rows  = 3 * (l + 1);
    if (2 * (d + 1) + 1 > rows) rows = 2 * (d + 1) + 1;
    total = (2 * n + 2) * (h + 2) * (rows + 1);
    en = 1'b1;
    #1;
    sample(0);
    for (int c = 1; c < total; c++) begin
      @(posedge clk);
      @(negedge clk);
      sample(c);
    end
    @(negedge clk);
    en = 1'b0;
    #1;
    check_quiet("R1");
  endtask

  initial begin
    #600000;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int ns[3] = '{0, 1, 3};
    int hs[3] = '{0, 1, 3};
    int idx = 0;
    rst_n = 1'b0; en = 1'b0; don = 1'b1; inv = 1'b0; spl = 1'b0; w8 = 1'b0;
    div = '0; xl = '0; ll = '0; bl = '0; pv = 1'b0; pd = '0; under = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_quiet("R1");
    foreach (ns[a]) begin
      foreach (hs[b]) begin
        for (int l = 0; l <= 2; l += 2) begin
          for (int d = 0; d <= 1; d++) begin
            run_case(ns[a], hs[b], l, d, idx[1], idx[0], idx[2], (idx % 5) != 4, (idx % 3) == 1);
            idx++;
          end
        end
      end
    end
    run_case(31, 0, 1, 0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);   // slowest shift clock
    run_case(0, 511, 0, 0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);  // longest row
    run_case(0, 0, 1023, 0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0); // tallest frame
    run_case(0, 0, 3, 255, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);  // slowest bias
    run_case(1, 2, 1, 0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);    // display off
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule